// File: doc/BRIEF.md
# Shutter Speed Code Interface

This block captures the electronic shutter setting of a CCD timing generator and turns it into a registered shutter-speed index for the line-count logic that follows it. The setting comes from one of two sources, chosen by a mode pin. In parallel mode three static select pins name the speed directly. In serial mode a three-wire port carries an eight-bit word: a data pin, a shift clock that captures one bit per rising edge, and a strobe whose falling edge commits the captured word. A flicker-less input and a TV-system input (NTSC or PAL) adjust the decoded result.

All pin activity is synchronized to the system clock. The shift clock and the strobe are detected as edges and are never used as clocks. A requested speed reaches the output only at a rising edge of the field sync input, so a field is never split. A move toward a faster shutter keeps the old value for one extra field. Until a first setting has been loaded, the valid flag stays low.

Top module: `shutter_code_if`

## Requirements
- R1: After reset, `speed_valid` is 0 and `speed_idx` is 0.
- R2: With `par_mode`=1, select code `sel` of value k (0 to 7) requests index k. Index 0 is normal (1/60 s NTSC, 1/50 s PAL), and indices 1 to 7 are 1/125, 1/250, 1/500, 1/1000, 1/2000, 1/4000 and 1/10000 s.
- R3: In serial mode the word is shifted in one bit per rising edge of `ser_clk`, with bit D0 sent first. Bits D2..D0 hold the speed code, with the same encoding as R2. Bit D3=1 requests flicker-less mode. Bits D7..D4 have no effect.
- R4: Shifting a word has no effect until `ser_strobe` falls. At that falling edge the shifted word becomes the serial request.
- R5: When `flk_mode`=1, or when the serial word has D3=1 in serial mode, the requested index is 8 (1/100 s) if `pal_mode`=0 and 9 (1/120 s) if `pal_mode`=1. This overrides the speed code.
- R6: In serial mode after reset, `speed_valid` stays 0 across field edges until a first word has been committed.
- R7: `speed_idx` and `speed_valid` change only in the clock cycle after a rising edge of `vsync` is sampled.
- R8: Exposure ranks from longest to shortest are: index 0, then indices 8 and 9, then indices 1 to 7. A request that is slower than or equal to the active value is loaded at the next field edge. A faster request is loaded only at a field edge where the same request was also present at the previous field edge. The first load after reset is immediate.
- R9: Once `speed_valid` is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 1 | 1 = parallel select pins, 0 = serial word |
| sel | input | 3 | Parallel speed select code |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial shift clock pin (asynchronous) |
| ser_strobe | input | 1 | Serial load strobe; its falling edge commits the word |
| flk_mode | input | 1 | Flicker-less mode request |
| pal_mode | input | 1 | 0 = NTSC, 1 = PAL |
| vsync | input | 1 | Field sync; its rising edge is the field boundary |
| speed_idx | output | 4 | Active shutter-speed index |
| speed_valid | output | 1 | A shutter setting has been established |

## Verification
The bench builds the block with its default parameters: an eight-bit serial word, three select bits and a two-stage synchronizer. This covers all eight parallel codes, the two flicker-less indices and the full serial word, including the upper bits that must be ignored. The serial pins are toggled several clocks apart, so the synchronizer latency is covered without any dependence on exact edge alignment. The field sequences include slower, equal and faster changes, which separate the immediate load from the one-field lag.

// File: rtl/shutter_code_if.sv
module shutter_code_if #(
  parameter int CODE_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             ser_strobe,
  input  logic             flk_mode,
  input  logic             pal_mode,
  input  logic             vsync,
  output logic [IDX_W-1:0] speed_idx,
  output logic             speed_valid
);
  localparam int FLK_BIT = SEL_W;
  localparam int WORD_W  = SEL_W + 1;
  localparam logic [IDX_W-1:0] IDX_FLK_NTSC = IDX_W'(2**SEL_W);
  localparam logic [IDX_W-1:0] IDX_FLK_PAL  = IDX_W'(2**SEL_W + 1);

  logic [SYNC_STAGES:0]   clk_sy, stb_sy;
  logic [SYNC_STAGES-1:0] dat_sy;
  logic [CODE_W-1:0]      shreg;
  logic [WORD_W-1:0]      word;
  logic                   have_word;
  logic                   vs_d;
  logic [IDX_W-1:0]       held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy <= '0;
      stb_sy <= '0;
      dat_sy <= '0;
    end else begin
      clk_sy <= {clk_sy[SYNC_STAGES-1:0], ser_clk};
      stb_sy <= {stb_sy[SYNC_STAGES-1:0], ser_strobe};
      dat_sy <= {dat_sy[SYNC_STAGES-2:0], ser_data};
    end

  wire clk_rise = clk_sy[SYNC_STAGES-1] & ~clk_sy[SYNC_STAGES];
  wire stb_fall = ~stb_sy[SYNC_STAGES-1] & stb_sy[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg     <= '0;
      word      <= '0;
      have_word <= 1'b0;
    end else begin
      if (clk_rise) shreg <= {dat_sy[SYNC_STAGES-1], shreg[CODE_W-1:1]};
      if (stb_fall) begin
        word      <= shreg[WORD_W-1:0];
        have_word <= 1'b1;
      end
    end

  wire [SEL_W-1:0] code    = par_mode ? sel : word[SEL_W-1:0];
  wire             flk_req = flk_mode | (~par_mode & word[FLK_BIT]);
  wire             req_ok  = par_mode | have_word;
  wire [IDX_W-1:0] req_idx = flk_req ? (pal_mode ? IDX_FLK_PAL : IDX_FLK_NTSC)
                                     : IDX_W'(code);

  function automatic logic [IDX_W-1:0] rank(input logic [IDX_W-1:0] i);
    if (i >= IDX_FLK_NTSC) rank = IDX_W'(1);
    else if (i == '0)      rank = '0;
    else                   rank = i + IDX_W'(1);
  endfunction

  wire vs_edge  = vsync & ~vs_d;
  wire may_load = !speed_valid || (rank(req_idx) <= rank(speed_idx)) || (held == req_idx);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vs_d        <= 1'b0;
      held        <= '0;
      speed_idx   <= '0;
      speed_valid <= 1'b0;
    end else begin
      vs_d <= vsync;
      if (vs_edge && req_ok) begin
        held <= req_idx;
        if (may_load) begin
          speed_idx   <= req_idx;
          speed_valid <= 1'b1;
        end
      end
    end
endmodule

// File: rtl/shutter_code_if_chk.sv
module shutter_code_if_chk #(
  parameter int SEL_W = 3,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync,
  input logic [IDX_W-1:0] speed_idx,
  input logic             speed_valid
);
  AST_INVALID_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_valid |-> speed_idx == '0); // R1
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    speed_idx <= IDX_W'(2**SEL_W + 1)); // R5
  AST_CHANGE_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(speed_idx) || !$stable(speed_valid)) |-> ($past(vsync) && !$past(vsync, 2))); // R7
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    speed_valid |=> speed_valid); // R9
endmodule

bind shutter_code_if shutter_code_if_chk #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync),
  .speed_idx(speed_idx), .speed_valid(speed_valid)
);

// File: tb/tb_shutter_code_if.sv
module tb_shutter_code_if;
  logic clk = 0, rst_n = 0;
  logic par_mode = 0, ser_data = 0, ser_clk = 0, ser_strobe = 0;
  logic flk_mode = 0, pal_mode = 0, vsync = 0;
  logic [2:0] sel = 0;
  logic [3:0] speed_idx;
  logic speed_valid;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  shutter_code_if dut (.clk(clk), .rst_n(rst_n), .par_mode(par_mode), .sel(sel),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_strobe(ser_strobe),
    .flk_mode(flk_mode), .pal_mode(pal_mode), .vsync(vsync),
    .speed_idx(speed_idx), .speed_valid(speed_valid));

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic field();
    vsync = 1; wait_n(4);
    vsync = 0; wait_n(4);
  endtask

  task automatic shift_word(logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      ser_data = w[i]; wait_n(4);
      ser_clk = 1;     wait_n(4);
      ser_clk = 0;     wait_n(4);
    end
  endtask

  task automatic strobe();
    ser_strobe = 1; wait_n(4);
    ser_strobe = 0; wait_n(6);
  endtask

  task automatic t_reset();
    check("R1 valid", speed_valid, 0);
    check("R1 idx", speed_idx, 0);
  endtask

  task automatic t_serial_uninit();
    par_mode = 0;
    field(); field();
    check("R6 valid before any word", speed_valid, 0);
  endtask

  task automatic t_strobe_commit();
    shift_word(8'h03);
    field();
    check("R4 no strobe no effect", speed_valid, 0);
    strobe();
    check("R7 held until field edge", speed_valid, 0);
    field();
    check("R3 serial code valid", speed_valid, 1);
    check("R3 serial code 3", speed_idx, 3);
  endtask

  task automatic t_upper_bits();
    shift_word(8'hF2); strobe();
    field();
    check("R3 upper bits ignored / R8 slower immediate", speed_idx, 2);
  endtask

  task automatic t_faster_lag();
    shift_word(8'h06); strobe();
    field();
    check("R8 faster lags one field", speed_idx, 2);
    field();
    check("R8 faster after second field", speed_idx, 6);
  endtask

  task automatic t_serial_flicker();
    shift_word(8'h08); strobe();
    field();
    check("R5 serial D3 NTSC", speed_idx, 8);
  endtask

  task automatic t_parallel();
    par_mode = 1; sel = 0;
    field();
    check("R2 sel 0 normal", speed_idx, 0);
    sel = 5; field();
    check("R8 parallel faster lag", speed_idx, 0);
    field();
    check("R2 sel 5", speed_idx, 5);
    sel = 1; field();
    check("R2 sel 1 slower immediate", speed_idx, 1);
    sel = 7; field(); field();
    check("R2 sel 7", speed_idx, 7);
  endtask

  task automatic t_flicker_pin();
    flk_mode = 1; pal_mode = 1; field();
    check("R5 flicker PAL", speed_idx, 9);
    pal_mode = 0; field();
    check("R5 flicker NTSC equal rank", speed_idx, 8);
    flk_mode = 0; sel = 4; wait_n(10);
    check("R7 no change without field edge", speed_idx, 8);
  endtask

  task automatic t_sticky();
    par_mode = 0; field();
    check("R9 valid stays", speed_valid, 1);
    check("R5 stored serial flicker word", speed_idx, 8);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1; wait_n(3);
    t_reset();
    t_serial_uninit();
    t_strobe_commit();
    t_upper_bits();
    t_faster_lag();
    t_serial_flicker();
    t_parallel();
    t_flicker_pin();
    t_sticky();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule